// File: doc/BRIEF.md
# Cache Invalidate-All Sequencer

This block owns the per-line valid and dirty state of a cache and runs a flash-invalidate over it. Software writes a two-bit control register. Bit 0 is the cache enable and bit 1 is the invalidate-all trigger. When the trigger is written as 1 together with enable set, the block starts a walk over every line index. The walk marks one line invalid per clock. Dirty lines lose their dirty mark and are never written back.

While the walk runs, the block raises a busy flag and drives the core stall from it. Any bus-side lookup whose request is sampled during the walk is answered as a miss. The trigger bit clears itself on the cycle the walk begins. Outside a walk, the block accepts line fills and answers core and bus lookups with one cycle of latency.

Top module: `cache_inval_seq`

## Requirements
- R1: After a synchronous reset, all lines read as invalid and clean, `busy` and `core_stall` are 0, and `ctl_rdata` reads 0.
- R2: A write with `ctl_wdata` = 2'b11 (bit 1 = invalidate, bit 0 = enable) while idle makes `ctl_rdata` read 2'b11 one cycle later. In the following cycle `busy` rises and `ctl_rdata[1]` reads 0.
- R3: Once started, `busy` stays high for exactly SETS consecutive cycles, one line index cleared per cycle.
- R4: After the walk, every line misses on lookup and reports dirty = 0, including lines that were dirty before the walk.
- R5: `core_stall` is high in exactly the cycles where `busy` is high.
- R6: A bus lookup sampled while `busy` is high returns `bus_hit` = 0 and `bus_dirty` = 0, even for a line not yet cleared.
- R7: A write with bit 1 set but enable (bit 0) clear starts no walk. `ctl_rdata[1]` stays 0 and valid lines stay valid.
- R8: A control write during a walk neither restarts nor extends it, and `ctl_rdata[1]` stays 0 while busy.
- R9: A fill while idle sets the line valid with the given dirty flag. A fill while busy is ignored.
- R10: `core_hit`, `bus_hit` and `bus_dirty` reflect the line state one clock after the request is sampled. A core lookup sampled while busy returns `core_hit` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Write data: bit 0 enable, bit 1 invalidate-all |
| ctl_rdata | output | 2 | Control register readback |
| fill_we | input | 1 | Line fill strobe |
| fill_idx | input | IDX_W | Line index of the fill |
| fill_dirty | input | 1 | Dirty flag stored with the fill |
| core_req | input | 1 | Core lookup request |
| core_idx | input | IDX_W | Core lookup index |
| core_hit | output | 1 | Core lookup hit, one cycle after request |
| core_stall | output | 1 | Stall to the core during a walk |
| bus_req | input | 1 | Bus-side lookup request |
| bus_idx | input | IDX_W | Bus lookup index |
| bus_hit | output | 1 | Bus lookup hit, one cycle after request |
| bus_dirty | output | 1 | Bus lookup dirty flag, one cycle after request |
| busy | output | 1 | Invalidate walk in progress |

## Verification
Lookup results are due one clock after the request edge, and the register readback is due one clock after the write. `busy` follows one clock after that, and the walk lasts SETS clocks. The bench drives inputs 1 ns after a rising edge and reads outputs 1 ns after the next edge, so each result is read in the cycle it is due. It counts the busy cycles one per edge until `busy` falls, which checks both the start cycle and the length. Stimulus inside the walk is applied at chosen cycle counts: a bus lookup to a line the walker has not yet reached, a repeated trigger write, and a fill to a line already cleared. Each is then checked at the ports after the walk ends.

// File: rtl/cinv_pkg.sv
package cinv_pkg;
  localparam int CTL_W       = 2;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_INV_BIT = 1;

  typedef struct packed {
    logic valid;
    logic dirty;
  } line_state_t;
endpackage

// File: rtl/cinv_ctl_reg.sv
module cinv_ctl_reg
  import cinv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             busy,
  output logic             start,
  output logic [CTL_W-1:0] rdata
);
  logic en_q;
  logic inv_q;

  // a pending trigger is consumed by the walker on the next edge
  assign start = inv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      if (we) en_q <= wdata[CTL_EN_BIT];
      if (inv_q)
        inv_q <= 1'b0;
      else if (we && !busy && wdata[CTL_INV_BIT] && wdata[CTL_EN_BIT])
        inv_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CTL_EN_BIT]  = en_q;
    rdata[CTL_INV_BIT] = inv_q;
  end
endmodule

// File: rtl/cinv_walker.sv
module cinv_walker #(
  parameter int SETS  = 64,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             clr_we,
  output logic [IDX_W-1:0] clr_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign clr_we  = busy_q;
  assign clr_idx = idx_q;
endmodule

// File: rtl/cinv_state_array.sv
module cinv_state_array
  import cinv_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  line_state_t      wdata,
  input  logic [IDX_W-1:0] core_raddr,
  output logic             core_valid,
  input  logic [IDX_W-1:0] bus_raddr,
  output line_state_t      bus_rdata
);
  line_state_t lines [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) lines[i] <= '0;
    end else if (we) begin
      lines[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_valid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      core_valid <= lines[core_raddr].valid;
      bus_rdata  <= lines[bus_raddr];
    end
  end
endmodule

// File: rtl/cache_inval_seq.sv
module cache_inval_seq
  import cinv_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_wdata,
  output logic [1:0]       ctl_rdata,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_dirty,
  input  logic             core_req,
  input  logic [IDX_W-1:0] core_idx,
  output logic             core_hit,
  output logic             core_stall,
  input  logic             bus_req,
  input  logic [IDX_W-1:0] bus_idx,
  output logic             bus_hit,
  output logic             bus_dirty,
  output logic             busy
);
  logic             start;
  logic             walk_busy;
  logic             clr_we;
  logic [IDX_W-1:0] clr_idx;
  logic             arr_we;
  logic [IDX_W-1:0] arr_waddr;
  line_state_t      arr_wdata;
  logic             core_valid;
  line_state_t      bus_rd;
  logic             core_ok_q;
  logic             bus_ok_q;

  cinv_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .busy  (walk_busy),
    .start (start),
    .rdata (ctl_rdata)
  );

  cinv_walker #(.SETS(SETS), .IDX_W(IDX_W)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (walk_busy),
    .clr_we  (clr_we),
    .clr_idx (clr_idx)
  );

  // the clear has priority; fills are dropped for the whole walk
  always_comb begin
    arr_we    = clr_we | (fill_we & ~walk_busy);
    arr_waddr = clr_we ? clr_idx : fill_idx;
    arr_wdata = clr_we ? line_state_t'('0) : '{valid: 1'b1, dirty: fill_dirty};
  end

  cinv_state_array #(.SETS(SETS), .IDX_W(IDX_W)) u_arr (
    .clk        (clk),
    .rst        (rst),
    .we         (arr_we),
    .waddr      (arr_waddr),
    .wdata      (arr_wdata),
    .core_raddr (core_idx),
    .core_valid (core_valid),
    .bus_raddr  (bus_idx),
    .bus_rdata  (bus_rd)
  );

  // qualifiers registered alongside the array read
  always_ff @(posedge clk) begin
    if (rst) begin
      core_ok_q <= 1'b0;
      bus_ok_q  <= 1'b0;
    end else begin
      core_ok_q <= core_req & ~walk_busy;
      bus_ok_q  <= bus_req & ~walk_busy;
    end
  end

  assign core_hit   = core_ok_q & core_valid;
  assign bus_hit    = bus_ok_q & bus_rd.valid;
  assign bus_dirty  = bus_ok_q & bus_rd.valid & bus_rd.dirty;
  assign busy       = walk_busy;
  assign core_stall = walk_busy;
endmodule

// File: rtl/cinv_checker.sv
module cinv_checker #(
  parameter int SETS = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       core_stall,
  input logic [1:0] ctl_rdata,
  input logic       core_hit,
  input logic       bus_hit,
  input logic       bus_dirty
);
  int run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= 0;
    else              run_cnt <= run_cnt + 1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!busy && !core_stall && ctl_rdata == 2'b00));

  p_trigger_selfclear_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !ctl_rdata[1]);

  p_walk_length_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_cnt == SETS);

  p_walk_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_cnt < SETS);

  p_stall_follows_busy_r5: assert property (@(posedge clk) disable iff (rst)
    core_stall == busy);

  p_bus_miss_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!bus_hit && !bus_dirty));

  p_start_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctl_rdata[0]));

  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ctl_rdata[1]);

  p_core_miss_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> !core_hit);
endmodule

bind cache_inval_seq cinv_checker #(.SETS(SETS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .core_stall (core_stall),
  .ctl_rdata  (ctl_rdata),
  .core_hit   (core_hit),
  .bus_hit    (bus_hit),
  .bus_dirty  (bus_dirty)
);

// File: tb/tb_cache_inval_seq.sv
`timescale 1ns/1ps
module tb_cache_inval_seq;
  localparam int SETS  = 64;
  localparam int IDX_W = 6;
  localparam int NVEC  = 10;
  localparam logic [1:0] OP_FILL = 2'd0, OP_BUS = 2'd1, OP_CORE = 2'd2;

  // {op, idx, dirty, exp_hit, exp_dirty}
  localparam logic [10:0] VEC [NVEC] = '{
    {OP_FILL, 6'd3,  1'b0, 2'b00},
    {OP_FILL, 6'd10, 1'b1, 2'b00},
    {OP_FILL, 6'd63, 1'b1, 2'b00},
    {OP_BUS,  6'd3,  1'b0, 2'b10},
    {OP_BUS,  6'd10, 1'b0, 2'b11},
    {OP_CORE, 6'd63, 1'b0, 2'b10},
    {OP_BUS,  6'd5,  1'b0, 2'b00},
    {OP_FILL, 6'd3,  1'b1, 2'b00},
    {OP_BUS,  6'd3,  1'b0, 2'b11},
    {OP_CORE, 6'd0,  1'b0, 2'b00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [1:0] ctl_wdata = '0;
  logic [1:0] ctl_rdata;
  logic fill_we = 1'b0;
  logic [IDX_W-1:0] fill_idx = '0;
  logic fill_dirty = 1'b0;
  logic core_req = 1'b0;
  logic [IDX_W-1:0] core_idx = '0;
  logic core_hit, core_stall;
  logic bus_req = 1'b0;
  logic [IDX_W-1:0] bus_idx = '0;
  logic bus_hit, bus_dirty, busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cache_inval_seq #(.SETS(SETS)) dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_look(input logic [IDX_W-1:0] i, input string req,
                          input int eh, input int ed);
    bus_req = 1'b1; bus_idx = i;
    tick();
    bus_req = 1'b0;
    chk(req, bus_hit, eh);
    chk(req, bus_dirty, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 stall", core_stall, 0);
    chk("R1 rdata", ctl_rdata, 0);
    bus_look(6'd17, "R1 line invalid", 0, 0);

    // R9, R10 vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op;
      op = VEC[v][10:9];
      if (op == OP_FILL) begin
        fill_we = 1'b1; fill_idx = VEC[v][8:3]; fill_dirty = VEC[v][2];
        tick();
        fill_we = 1'b0;
      end else if (op == OP_BUS) begin
        bus_look(VEC[v][8:3], "R10 bus lookup", VEC[v][1], VEC[v][0]);
      end else begin
        core_req = 1'b1; core_idx = VEC[v][8:3];
        tick();
        core_req = 1'b0;
        chk("R10 core lookup", core_hit, VEC[v][1]);
      end
    end

    // R7 trigger without enable
    ctl_we = 1'b1; ctl_wdata = 2'b10;
    tick();
    ctl_we = 1'b0;
    chk("R7 rdata", ctl_rdata, 0);
    tick();
    chk("R7 busy", busy, 0);
    bus_look(6'd10, "R7 line kept", 1, 1);

    // R2 start
    ctl_we = 1'b1; ctl_wdata = 2'b11;
    tick();
    ctl_we = 1'b0;
    chk("R2 pending", ctl_rdata, 3);
    chk("R2 not yet busy", busy, 0);
    tick();
    chk("R2 busy", busy, 1);
    chk("R2 selfclear", ctl_rdata, 1);
    chk("R5 stall", core_stall, 1);

    // walk: R3 length, R6 forced miss, R8 rewrite, R9 fill ignored
    cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      if (cnt == 2) begin bus_req = 1'b1; bus_idx = 6'd63; end
      if (cnt == 10) begin ctl_we = 1'b1; ctl_wdata = 2'b11; end
      if (cnt == 40) begin fill_we = 1'b1; fill_idx = 6'd0; fill_dirty = 1'b1; end
      tick();
      if (cnt == 2) begin
        bus_req = 1'b0;
        chk("R6 bus miss", bus_hit, 0);
        chk("R6 bus dirty", bus_dirty, 0);
      end
      if (cnt == 10) begin
        ctl_we = 1'b0;
        chk("R8 rdata", ctl_rdata, 1);
      end
      if (cnt == 40) fill_we = 1'b0;
      if (busy != core_stall) chk("R5 stall tracks", core_stall, busy);
    end
    chk("R3 R8 busy cycles", cnt, SETS);
    chk("R5 stall off", core_stall, 0);
    tick();
    chk("R8 no restart", busy, 0);

    // R4 all invalid, dirty discarded
    bus_look(6'd10, "R4 dirty line", 0, 0);
    bus_look(6'd63, "R4 last line", 0, 0);
    bus_look(6'd3, "R4 line", 0, 0);
    bus_look(6'd0, "R9 busy fill ignored", 0, 0);
    core_req = 1'b1; core_idx = 6'd3;
    tick();
    core_req = 1'b0;
    chk("R4 core miss", core_hit, 0);

    // R9 fills work again once idle
    fill_we = 1'b1; fill_idx = 6'd7; fill_dirty = 1'b0;
    tick();
    fill_we = 1'b0;
    bus_look(6'd7, "R9 refill", 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule